// File: doc/BRIEF.md
# Watchdog Timer with Free-Running Prescaler

The block watches over software and forces a system reset when the software stops servicing it. A prescaler runs freely on the bus clock and produces one tick every 2^PRESCALE_BITS bus clocks. The default is 2^15. Software servicing never clears the prescaler. The ticks feed a second counter, and a two-bit rate select sets how many ticks make up one watchdog period. When the period runs out without a service, the block drives a reset pulse of fixed length. It also sets a sticky flag so that boot code can see that the watchdog caused the reset.

To service the watchdog, software writes a two-byte key to the service register. Only a complete, correctly ordered key clears the tick counter. The prescaler keeps its phase, so the time to a timeout is never less than the nominal period. It can exceed the nominal period by up to one tick, at any rate setting.

A reset-disable bit suppresses timeouts. In special mode this bit comes out of reset set, and software may change it. In normal mode it is held clear. Every input is a plain control strobe or level. No streaming data passes through the block, so there is no valid/ready handshake and no back-pressure. Every write is accepted in the cycle it is presented.

Top module: `wdog_top`

## Requirements
- R1: After rst_n is released, wdt_rst and wdt_cause are both 0.
- R2: The prescaler is never cleared by servicing. A timeout occurs between N·2^P+1 and (N+1)·2^P bus clock edges after the edge that accepts the completing service write, where P is PRESCALE_BITS.
- R3: rate_sel values 00, 01, 10 and 11 set N to 1, 4, 16 and 64 prescaler ticks.
- R4: A write of 0x55 and a later write of 0xAA on svc_we/svc_data is a valid service, and it clears the tick counter. Servicing more often than the period prevents any timeout.
- R5: A write of any value other than 0x55 or 0xAA disarms the key. A write of 0xAA without an armed 0x55 does nothing. Neither case counts as a service.
- R6: A timeout drives wdt_rst high for exactly 4 consecutive bus clocks.
- R7: wdt_cause is set in the same edge that starts the pulse. It stays 1 through later services and timeouts until rst_n.
- R8: When special_mode is 1 during reset, the disable bit resets to 1 and no pulse occurs. Writing 0 through dis_we/dis_wdata re-enables timeouts.
- R9: When special_mode is 0, disable writes are ignored and timeouts still occur.
- R10: While enable is 0 the tick counter is held clear and no timeout occurs.
- R11: After an expiry, counting restarts from zero. Without service, timeouts repeat once per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Watchdog enable |
| rate_sel | input | RATE_W | Period select, N = 4^rate_sel ticks |
| svc_we | input | 1 | Service register write strobe |
| svc_data | input | 8 | Service register write data |
| special_mode | input | 1 | 1 = special mode, disable bit writable |
| dis_we | input | 1 | Disable bit write strobe |
| dis_wdata | input | 1 | Disable bit write value |
| wdt_rst | output | 1 | Watchdog reset pulse |
| wdt_cause | output | 1 | Sticky flag: watchdog caused a reset |

## Verification
The assertions check four things on every cycle. The prescaler never ticks in two adjacent cycles. No expiry happens in the cycle after a completed service. Every reset pulse lasts four cycles and only starts while the disable bit is clear. The cause flag never drops outside reset. The timing window for each rate, the rejection of broken or lone keys, the disable bit in each mode, the effect of the enable input and repeated timeouts all need whole sequences, so only the directed bench scenarios can show them.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
  localparam int unsigned PULSE_LEN = 4;
  localparam int unsigned PULSE_W   = $clog2(PULSE_LEN + 1);

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_state_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned PRESCALE_BITS = 15
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  logic [PRESCALE_BITS-1:0] cnt_q;

  // Free-running: no service input reaches this counter.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = &cnt_q;

  p_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_svc_seq.sv
module wdog_svc_seq
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [7:0] data_i,
  output logic       done_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    done_o  = 1'b0;
    if (we_i) begin
      if (data_i == KEY_ARM) begin
        state_d = SEQ_ARMED;
      end else if (data_i == KEY_FIRE) begin
        done_o  = (state_q == SEQ_ARMED);
        state_d = SEQ_IDLE;
      end else begin
        state_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/wdog_divider.sv
module wdog_divider #(
  parameter int unsigned RATE_W         = 2,
  parameter int unsigned RATE_STEP_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              tick_i,
  input  logic              clear_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              expire_o
);
  localparam int unsigned RATES = 2 ** RATE_W;
  localparam int unsigned DIV_W = RATE_STEP_LOG2 * (RATES - 1) + 1;

  logic [DIV_W-1:0] lim_tab [RATES];
  logic [DIV_W-1:0] limit;
  logic [DIV_W-1:0] cnt_q;

  for (genvar i = 0; i < RATES; i++) begin : g_lim
    assign lim_tab[i] = DIV_W'(1) << (RATE_STEP_LOG2 * i);
  end

  assign limit    = lim_tab[rate_i];
  assign expire_o = enable_i && !clear_i && tick_i && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!enable_i || clear_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q >= limit) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  p_svc_no_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !expire_o);
  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |-> !expire_o);
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic rst_o,
  output logic cause_o
);
  logic [PULSE_W-1:0] len_q;
  logic               cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      cause_q <= 1'b0;
    end else begin
      if (fire_i)            len_q <= PULSE_W'(PULSE_LEN);
      else if (len_q != '0)  len_q <= len_q - 1'b1;
      if (fire_i)            cause_q <= 1'b1;
    end
  end

  assign rst_o   = (len_q != '0);
  assign cause_o = cause_q;

  p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o) |-> ($past(rst_o, 1) && $past(rst_o, 4)));
  p_cause_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cause_o |=> cause_o);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned PRESCALE_BITS  = 15,
  parameter int unsigned RATE_W         = 2,
  parameter int unsigned RATE_STEP_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              svc_we,
  input  logic [7:0]        svc_data,
  input  logic              special_mode,
  input  logic              dis_we,
  input  logic              dis_wdata,
  output logic              wdt_rst,
  output logic              wdt_cause
);
  logic tick, svc_done, expire, fire;
  logic dis_q, dis_eff;

  // Disable bit: set out of reset, honoured and writable only in special mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             dis_q <= 1'b1;
    else if (!special_mode) dis_q <= 1'b0;
    else if (dis_we)        dis_q <= dis_wdata;
  end
  assign dis_eff = dis_q & special_mode;

  wdog_prescaler #(.PRESCALE_BITS(PRESCALE_BITS)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  wdog_svc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .we_i(svc_we), .data_i(svc_data), .done_o(svc_done)
  );

  wdog_divider #(.RATE_W(RATE_W), .RATE_STEP_LOG2(RATE_STEP_LOG2)) u_div (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .tick_i(tick),
    .clear_i(svc_done), .rate_i(rate_sel), .expire_o(expire)
  );

  assign fire = expire & ~dis_eff;

  wdog_rst_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .rst_o(wdt_rst), .cause_o(wdt_cause)
  );

  p_no_fire_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $past(!dis_eff && enable));
  p_cause_with_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> wdt_cause);
endmodule

// File: tb/sim_wdog_top.sv
module sim_wdog_top;
  localparam int CLK_PERIOD = 10;
  localparam int PB   = 4;
  localparam int TICK = 2 ** PB;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [1:0] rate_sel = '0;
  logic svc_we = 1'b0, special_mode = 1'b0, dis_we = 1'b0, dis_wdata = 1'b0;
  logic [7:0] svc_data = '0;
  logic wdt_rst, wdt_cause;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_top #(.PRESCALE_BITS(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate_sel(rate_sel),
    .svc_we(svc_we), .svc_data(svc_data), .special_mode(special_mode),
    .dis_we(dis_we), .dis_wdata(dis_wdata), .wdt_rst(wdt_rst), .wdt_cause(wdt_cause)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired: actual %0d cycles, expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit spec);
    @(negedge clk);
    rst_n = 1'b0; special_mode = spec; enable = 1'b0; svc_we = 1'b0;
    dis_we = 1'b0; rate_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); svc_we = 1'b1; svc_data = v;
    @(negedge clk); svc_we = 1'b0;
  endtask

  task automatic service();
    wr(8'h55); wr(8'hAA);
  endtask

  // Counts edges until wdt_rst is seen high, up to maxc.
  task automatic wait_rise(input int maxc, output int d);
    d = 0;
    while (d < maxc) begin
      @(negedge clk); d++;
      if (wdt_rst) return;
    end
    d = maxc + 1;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    @(negedge clk);
    check(wdt_rst == 1'b0, "R1", "wdt_rst after reset", wdt_rst, 0);
    check(wdt_cause == 1'b0, "R1", "wdt_cause after reset", wdt_cause, 0);
  endtask

  task automatic t_rate(input int r);
    int n, d;
    n = 1 << (2 * r);
    do_reset(1'b0);
    enable = 1'b1; rate_sel = 2'(r);
    service();
    wait_rise((n + 2) * TICK, d);
    check(d >= n * TICK + 1 && d <= (n + 1) * TICK, "R2", "timeout edges", d, n * TICK + 1);
    check(d > n * TICK, "R3", "rate period", d, n * TICK + 1);
  endtask

  task automatic t_pulse_cause();
    int d, hi;
    do_reset(1'b0);
    enable = 1'b1; rate_sel = 2'd0;
    service();
    wait_rise(4 * TICK, d);
    check(wdt_cause == 1'b1, "R7", "cause with pulse", wdt_cause, 1);
    hi = 1;
    while (hi < 10) begin
      @(negedge clk);
      if (!wdt_rst) break;
      hi++;
    end
    check(hi == 4, "R6", "pulse width", hi, 4);
    // The next timeout follows one period after the expiry (R11).
    wait_rise(4 * TICK, d);
    check(d >= TICK + 1 - 4 && d <= 2 * TICK - 4 + 1, "R11", "repeat timeout", d, 2 * TICK - 4);
    repeat (3) service();
    check(wdt_cause == 1'b1, "R7", "cause sticky after service", wdt_cause, 1);
  endtask

  task automatic t_keep_alive();
    int seen = 0;
    do_reset(1'b0);
    enable = 1'b1; rate_sel = 2'd0;
    for (int i = 0; i < 20; i++) begin
      service();
      repeat (6) begin @(negedge clk); if (wdt_rst) seen++; end
    end
    check(seen == 0, "R4", "no pulse with regular service", seen, 0);
    check(wdt_cause == 1'b0, "R4", "cause stays clear", wdt_cause, 0);
  endtask

  task automatic t_bad_key(input bit lone);
    int d, pre;
    do_reset(1'b0);
    enable = 1'b1; rate_sel = 2'd1;
    service();
    repeat (30) @(negedge clk);
    if (lone) begin wr(8'hAA); pre = 32; end
    else begin wr(8'h55); wr(8'h12); wr(8'hAA); pre = 36; end
    wait_rise(6 * TICK, d);
    d += pre;
    check(d >= 4 * TICK + 1 && d <= 5 * TICK, "R5", lone ? "lone key ignored" : "broken key ignored",
          d, 5 * TICK);
  endtask

  task automatic t_disable_special();
    int seen = 0, d;
    do_reset(1'b1);
    enable = 1'b1; rate_sel = 2'd0;
    service();
    repeat (100) begin @(negedge clk); if (wdt_rst) seen++; end
    check(seen == 0, "R8", "suppressed in special mode", seen, 0);
    check(wdt_cause == 1'b0, "R8", "cause clear while suppressed", wdt_cause, 0);
    @(negedge clk); dis_we = 1'b1; dis_wdata = 1'b0;
    @(negedge clk); dis_we = 1'b0;
    service();
    wait_rise(4 * TICK, d);
    check(d >= TICK + 1 && d <= 2 * TICK, "R8", "re-enabled timeout", d, 2 * TICK);
  endtask

  task automatic t_disable_normal();
    int d;
    do_reset(1'b0);
    enable = 1'b1; rate_sel = 2'd0;
    @(negedge clk); dis_we = 1'b1; dis_wdata = 1'b1;
    @(negedge clk); dis_we = 1'b0;
    service();
    wait_rise(4 * TICK, d);
    check(d >= TICK + 1 && d <= 2 * TICK, "R9", "disable write ignored", d, 2 * TICK);
  endtask

  task automatic t_enable();
    int seen = 0, d;
    do_reset(1'b0);
    enable = 1'b0; rate_sel = 2'd0;
    repeat (100) begin @(negedge clk); if (wdt_rst) seen++; end
    check(seen == 0, "R10", "no pulse while disabled", seen, 0);
    enable = 1'b1;
    service();
    wait_rise(4 * TICK, d);
    check(d >= TICK + 1 && d <= 2 * TICK, "R10", "timeout after enable", d, 2 * TICK);
  endtask

  initial begin
    t_reset();
    for (int r = 0; r < 4; r++) t_rate(r);
    t_pulse_cause();
    t_keep_alive();
    t_bad_key(1'b0);
    t_bad_key(1'b1);
    t_disable_special();
    t_disable_normal();
    t_enable();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule